// File: doc/BRIEF.md
# Three-channel timer and pulse measurement unit

This block holds three identical 24-bit counter channels that share one 21-bit clock divider. Every channel owns a single pin and, depending on its mode, runs that pin as a plain I/O line, counts edges arriving on it, or times the high phase or the full period of the incoming signal. In the output modes the channel drives the pin as a periodic toggle, as a watchdog that trips when software stops restarting it, or as a PWM waveform set by a compare value.

Software reaches the block through a flat register port: a write strobe, an address, write data and read data that is combinational. Each channel raises its own interrupt line when its count event occurs. A watchdog expiry on any channel also raises a shared reset-request output. Every pin input passes through a two-flop synchronizer before its edges are detected on the system clock.

Top module: `tmr3_top`

## Requirements
- R1: After reset, every register reads zero, and pin_oe, pin_out, irq and wd_rst_req are all low. Registers are addressed as addr[4:3] = channel and addr[2:0] = select: 0 control, 1 reload, 2 compare, 3 capture (read-only), 4 live count (read-only). Channel 3 with select 0 is the divider register.
- R2: Control register fields are: [2:0] mode, [3] enable, [4] external clock, [5] interrupt enable, [6] output level, [7] synchronized pin level (read-only), [8] pending (write 1 to clear). In mode 0 the pin is an input and bit 7 follows it two clocks after it changes. In mode 1 the pin drives the value of bit 6.
- R3: pin_oe is high only in modes 1, 5, 6 and 7. The mode codes are 2 event count, 3 pulse width, 4 period, 5 toggle, 6 watchdog and 7 PWM.
- R4: Any write to a control register clears that channel's count. While the enable bit is 0, the count does not change.
- R5: With divider value D, the internal tick occurs once every D+1 clocks. When the divider is written one clock before the control register, the count in mode 2 is zero n clocks after the control write if n < max(D,1), and otherwise (n - max(D,1))/(D+1) + 1.
- R6: When bit 4 is set, a counting channel advances once for each rising edge on its pin. Each edge takes effect two clocks after it appears.
- R7: When a tick arrives while the count equals the reload value, the count returns to 0 and pending is set. irq equals pending AND the interrupt enable bit. Writing 1 to bit 8 clears pending.
- R8: In mode 3 with D=0, a high pulse of W clocks stores W in the capture register, clears the count and sets pending.
- R9: In mode 4 with D=0, rising edges P clocks apart store P in the capture register.
- R10: In mode 5 the pin starts low after the control write and inverts at every wrap, so with reload 3 and D=0 it goes high 4 clocks after the write and low again 8 clocks after it.
- R11: In mode 7 the pin is high while count < compare and low otherwise, so a compare value of 0 keeps it low.
- R12: In mode 6, reaching the reload value with no control write sets the channel's expired state. The count then stays at 0, the pin and wd_rst_req go high, and they stay high until the next control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Channel and register select |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Combinational read data |
| pin_in | input | 3 | Pin input level per channel |
| pin_out | output | 3 | Pin output level per channel |
| pin_oe | output | 3 | Pin output enable per channel |
| irq | output | 3 | Interrupt per channel |
| wd_rst_req | output | 1 | Watchdog reset request |

## Verification
A register write takes effect at the clock edge on which it is strobed. Counting begins on the edge after a control write, and the bench counts every edge from that point before sampling count, pin_out or irq in the low clock phase. Each pin edge reaches the counter, the capture register or pending two edges after the pin changes, so every pulse the bench drives is held long enough for that edge to land inside the window. The bench predicts the random divider and count samples with a formula function and compares them at the cycle the formula gives.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    M_GPI = 3'd0,
    M_GPO = 3'd1,
    M_EVT = 3'd2,
    M_PW  = 3'd3,
    M_PER = 3'd4,
    M_TOG = 3'd5,
    M_WD  = 3'd6,
    M_PWM = 3'd7
  } mode_e;

  localparam int CB_EN   = 3;
  localparam int CB_EXT  = 4;
  localparam int CB_IEN  = 5;
  localparam int CB_GOUT = 6;
  localparam int CB_PEND = 8;
  localparam int CTRL_W  = 9;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] div,
  output logic          tick
);
  logic [PW-1:0] div_q, div_n, cnt_q, cnt_n;

  assign tick = (cnt_q == '0);
  assign div  = div_q;

  always_comb begin
    div_n = div_q;
    cnt_n = cnt_q;
    if (wr) begin
      div_n = wdata;
      cnt_n = wdata;
    end else if (tick) begin
      cnt_n = div_q;
    end else begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [2:0] s_q, s_n;

  assign s_n  = {s_q[1:0], pin};
  assign lvl  = s_q[1];
  assign rise = s_q[1] & ~s_q[2];
  assign fall = ~s_q[1] & s_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= '0;
    else        s_q <= s_n;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_tick,
  input  logic          lvl,
  input  logic          rise,
  input  logic          fall,
  input  logic          wr_ctrl,
  input  logic          wr_rld,
  input  logic          wr_cmp,
  input  logic [CW-1:0] wdata,
  output mode_e         mode,
  output logic          en,
  output logic          ext,
  output logic          ien,
  output logic          gout,
  output logic          pend,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cap,
  output logic [CW-1:0] rld,
  output logic [CW-1:0] cmp,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          irq,
  output logic          wd_exp
);
  mode_e         mode_q, mode_n;
  logic          en_q, en_n, ext_q, ext_n, ien_q, ien_n, gout_q, gout_n;
  logic          pend_q, pend_n, tog_q, tog_n, exp_q, exp_n;
  logic [CW-1:0] cnt_q, cnt_n, cap_q, cap_n, rld_q, rld_n, cmp_q, cmp_n;
  logic          tick, hit, evt;

  assign tick = ext_q ? rise : pre_tick;
  assign hit  = (cnt_q == rld_q);

  always_comb begin
    mode_n = mode_q;  en_n = en_q;  ext_n = ext_q;  ien_n = ien_q;
    gout_n = gout_q;  pend_n = pend_q;  tog_n = tog_q;  exp_n = exp_q;
    cnt_n  = cnt_q;   cap_n = cap_q;  rld_n = rld_q;  cmp_n = cmp_q;
    evt    = 1'b0;
    if (en_q) begin
      unique case (mode_q)
        M_EVT, M_TOG, M_PWM, M_WD: begin
          if (tick && !exp_q) begin
            if (hit) begin
              cnt_n = '0;
              evt   = 1'b1;
              if (mode_q == M_WD) exp_n = 1'b1;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        M_PW: begin
          if (fall) begin
            cap_n = cnt_q;
            cnt_n = '0;
            evt   = 1'b1;
          end else if (pre_tick && lvl) begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        M_PER: begin
          if (rise) begin
            cap_n = cnt_q;
            cnt_n = {{(CW-1){1'b0}}, pre_tick};
            evt   = 1'b1;
          end else if (pre_tick) begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (evt && mode_q == M_TOG) tog_n = ~tog_q;
    pend_n = pend_q | evt;
    if (wr_rld) rld_n = wdata;
    if (wr_cmp) cmp_n = wdata;
    if (wr_ctrl) begin
      mode_n = mode_e'(wdata[2:0]);
      en_n   = wdata[CB_EN];
      ext_n  = wdata[CB_EXT];
      ien_n  = wdata[CB_IEN];
      gout_n = wdata[CB_GOUT];
      pend_n = pend_q & ~wdata[CB_PEND];
      cnt_n  = '0;
      tog_n  = 1'b0;
      exp_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_GPI;  en_q <= 1'b0;  ext_q <= 1'b0;  ien_q <= 1'b0;
      gout_q <= 1'b0;   pend_q <= 1'b0; tog_q <= 1'b0; exp_q <= 1'b0;
      cnt_q  <= '0;     cap_q <= '0;    rld_q <= '0;   cmp_q <= '0;
    end else begin
      mode_q <= mode_n; en_q <= en_n;   ext_q <= ext_n; ien_q <= ien_n;
      gout_q <= gout_n; pend_q <= pend_n; tog_q <= tog_n; exp_q <= exp_n;
      cnt_q  <= cnt_n;  cap_q <= cap_n;  rld_q <= rld_n; cmp_q <= cmp_n;
    end
  end

  always_comb begin
    unique case (mode_q)
      M_GPO:   pin_out = gout_q;
      M_TOG:   pin_out = tog_q;
      M_WD:    pin_out = exp_q;
      M_PWM:   pin_out = (cnt_q < cmp_q);
      default: pin_out = 1'b0;
    endcase
  end

  assign pin_oe = (mode_q == M_GPO) || (mode_q == M_TOG) ||
                  (mode_q == M_WD)  || (mode_q == M_PWM);
  assign irq    = pend_q & ien_q;
  assign mode   = mode_q;
  assign en     = en_q;
  assign ext    = ext_q;
  assign ien    = ien_q;
  assign gout   = gout_q;
  assign pend   = pend_q;
  assign cnt    = cnt_q;
  assign cap    = cap_q;
  assign rld    = rld_q;
  assign cmp    = cmp_q;
  assign wd_exp = exp_q;
endmodule

// File: rtl/tmr3_top.sv
module tmr3_top
  import tmr_pkg::*;
#(
  parameter  int NCH = 3,
  parameter  int CW  = 24,
  parameter  int PW  = 21,
  localparam int CHW = $clog2(NCH + 1),
  localparam int AW  = CHW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [CW-1:0]  reg_wdata,
  output logic [CW-1:0]  reg_rdata,
  input  logic [NCH-1:0] pin_in,
  output logic [NCH-1:0] pin_out,
  output logic [NCH-1:0] pin_oe,
  output logic [NCH-1:0] irq,
  output logic           wd_rst_req
);
  logic [1:0]     rs_q;
  logic           rst_sn;
  logic [CHW-1:0] a_ch;
  logic [2:0]     a_sel;
  logic           pre_tick;
  logic [PW-1:0]  pre_div;

  mode_e          mode_v [NCH];
  logic [CW-1:0]  cnt_v [NCH];
  logic [CW-1:0]  cap_v [NCH];
  logic [CW-1:0]  rld_v [NCH];
  logic [CW-1:0]  cmp_v [NCH];
  logic [NCH-1:0] en_v, ext_v, ien_v, gout_v, pend_v, exp_v;
  logic [NCH-1:0] lvl_v, rise_v, fall_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  assign a_ch  = reg_addr[AW-1:3];
  assign a_sel = reg_addr[2:0];

  tmr_prescaler #(.PW(PW)) u_pre (
    .clk   (clk),
    .rst_n (rst_sn),
    .wr    (reg_wr && a_ch == CHW'(NCH) && a_sel == 3'd0),
    .wdata (reg_wdata[PW-1:0]),
    .div   (pre_div),
    .tick  (pre_tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel_me;
    assign sel_me = reg_wr && (a_ch == CHW'(g));

    tmr_pin_sync u_sync (
      .clk   (clk),
      .rst_n (rst_sn),
      .pin   (pin_in[g]),
      .lvl   (lvl_v[g]),
      .rise  (rise_v[g]),
      .fall  (fall_v[g])
    );

    tmr_channel #(.CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_sn),
      .pre_tick (pre_tick),
      .lvl      (lvl_v[g]),
      .rise     (rise_v[g]),
      .fall     (fall_v[g]),
      .wr_ctrl  (sel_me && a_sel == 3'd0),
      .wr_rld   (sel_me && a_sel == 3'd1),
      .wr_cmp   (sel_me && a_sel == 3'd2),
      .wdata    (reg_wdata),
      .mode     (mode_v[g]),
      .en       (en_v[g]),
      .ext      (ext_v[g]),
      .ien      (ien_v[g]),
      .gout     (gout_v[g]),
      .pend     (pend_v[g]),
      .cnt      (cnt_v[g]),
      .cap      (cap_v[g]),
      .rld      (rld_v[g]),
      .cmp      (cmp_v[g]),
      .pin_out  (pin_out[g]),
      .pin_oe   (pin_oe[g]),
      .irq      (irq[g]),
      .wd_exp   (exp_v[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (a_ch == CHW'(NCH) && a_sel == 3'd0) reg_rdata = CW'(pre_div);
    for (int i = 0; i < NCH; i++) begin
      if (a_ch == CHW'(i)) begin
        unique case (a_sel)
          3'd0: reg_rdata = CW'({pend_v[i], lvl_v[i], gout_v[i], ien_v[i],
                                 ext_v[i], en_v[i], mode_v[i]});
          3'd1: reg_rdata = rld_v[i];
          3'd2: reg_rdata = cmp_v[i];
          3'd3: reg_rdata = cap_v[i];
          3'd4: reg_rdata = cnt_v[i];
          default: reg_rdata = '0;
        endcase
      end
    end
  end

  assign wd_rst_req = |exp_v;
endmodule

// File: rtl/tmr3_sva.sv
module tmr3_sva
  import tmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter int CW  = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] pin_oe,
  input logic [NCH-1:0] pin_out,
  input logic [NCH-1:0] irq,
  input logic           wd_rst_req,
  input mode_e          mode_v [NCH],
  input logic [NCH-1:0] en_v,
  input logic [NCH-1:0] ien_v,
  input logic [NCH-1:0] exp_v,
  input logic [CW-1:0]  cnt_v [NCH],
  input logic [CW-1:0]  cmp_v [NCH]
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    p_oe_outmodes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[i] |-> (mode_v[i] == M_GPO || mode_v[i] == M_TOG ||
                     mode_v[i] == M_WD  || mode_v[i] == M_PWM));

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> ien_v[i]);

    p_hold_dis_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !en_v[i] |=> (cnt_v[i] == $past(cnt_v[i]) || cnt_v[i] == '0));

    p_wd_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exp_v[i]) |-> (cnt_v[i] == '0 && wd_rst_req));

    p_pwm_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_v[i] == M_PWM && cnt_v[i] == '0 && cmp_v[i] != '0) |-> pin_out[i]);
  end
endmodule

bind tmr3_top tmr3_sva #(.NCH(NCH), .CW(CW)) u_sva (
  .clk        (clk),
  .rst_n      (rst_sn),
  .pin_oe     (pin_oe),
  .pin_out    (pin_out),
  .irq        (irq),
  .wd_rst_req (wd_rst_req),
  .mode_v     (mode_v),
  .en_v       (en_v),
  .ien_v      (ien_v),
  .exp_v      (exp_v),
  .cnt_v      (cnt_v),
  .cmp_v      (cmp_v)
);

// File: tb/tmr3_top_tb.sv
`timescale 1ns/1ps
module tmr3_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic [2:0]  pin_in = '0;
  logic [2:0]  pin_out, pin_oe, irq;
  logic        wd_rst_req;
  int n_chk = 0;
  int n_fail = 0;

  tmr3_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .wd_rst_req(wd_rst_req)
  );

  always #2 clk = ~clk;

  function automatic logic [4:0] ad(input int ch, input int sel);
    return {ch[1:0], sel[2:0]};
  endfunction

  function automatic logic [23:0] ctl(input int mode, input bit en, input bit ext,
                                      input bit ien, input bit gout, input bit clr);
    return {15'd0, clr, 1'b0, gout, ien, ext, en, mode[2:0]};
  endfunction

  function automatic int exp_count(input int d, input int n);
    int f;
    f = (d > 1) ? d : 1;
    return (n < f) ? 0 : (n - f) / (d + 1) + 1;
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [23:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog timeout");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_n(4);

    // R1 reset state
    for (int s = 0; s < 5; s++) begin
      rd(ad(0, s), v); chk("R1 reg after reset", v, 0);
    end
    rd(ad(3, 0), v); chk("R1 divider after reset", v, 0);
    chk("R1 outputs after reset", int'({pin_oe, pin_out, irq, wd_rst_req}), 0);

    // R2 GPIO output and input
    wr(ad(0, 0), ctl(1, 0, 0, 0, 1, 0));
    chk("R2 gpio out level", pin_out[0], 1);
    chk("R3 gpio out oe", pin_oe[0], 1);
    wr(ad(0, 0), ctl(1, 0, 0, 0, 0, 0));
    chk("R2 gpio out low", pin_out[0], 0);
    pin_in[1] = 1'b1;
    wait_n(2);
    rd(ad(1, 0), v); chk("R2 gpio in level bit7", (v >> 7) & 1, 1);
    chk("R3 gpio in oe low", pin_oe[1], 0);
    pin_in[1] = 1'b0;
    wait_n(3);

    // R4 disabled channel holds count
    wr(ad(1, 1), 24'hFFFFFF);
    wr(ad(3, 0), 24'd0);
    wr(ad(1, 0), ctl(2, 0, 0, 0, 0, 0));
    wait_n(10);
    rd(ad(1, 4), v); chk("R4 disabled count", v, 0);
    wr(ad(1, 0), ctl(2, 1, 0, 0, 0, 0));
    wait_n(7);
    rd(ad(1, 4), v); chk("R4 enabled count", v, 7);
    wr(ad(1, 0), ctl(2, 0, 0, 0, 0, 0));
    wait_n(5);
    rd(ad(1, 4), v); chk("R4 ctrl write clears and holds", v, 0);

    // R5 random divider and sample points
    wr(ad(0, 1), 24'hFFFFFF);
    for (int it = 0; it < 24; it++) begin
      int d, n;
      d = (it == 0) ? 0 : int'($urandom_range(7, 0));
      n = (it == 1) ? 0 : int'($urandom_range(60, 0));
      wr(ad(3, 0), 24'(d));
      wr(ad(0, 0), ctl(2, 1, 0, 0, 0, 0));
      wait_n(n);
      rd(ad(0, 4), v); chk("R5 prescaled count", v, exp_count(d, n));
    end
    rd(ad(3, 0), v); chk("R5 divider readback", v >= 0 && v <= 7 ? 1 : 0, 1);

    // R6/R7 external event counting with reload 4
    wr(ad(2, 1), 24'd4);
    wr(ad(2, 0), ctl(2, 1, 1, 1, 0, 0));
    for (int p = 0; p < 4; p++) begin
      pin_in[2] = 1'b1; wait_n(2); pin_in[2] = 1'b0; wait_n(2);
    end
    rd(ad(2, 4), v); chk("R6 four edges counted", v, 4);
    chk("R7 no irq before wrap", irq[2], 0);
    pin_in[2] = 1'b1; wait_n(2); pin_in[2] = 1'b0; wait_n(2);
    rd(ad(2, 4), v); chk("R7 wrap to zero", v, 0);
    chk("R7 irq on wrap", irq[2], 1);
    wr(ad(2, 0), ctl(2, 0, 1, 1, 0, 1));
    chk("R7 irq cleared", irq[2], 0);

    // R7 enable gating
    wr(ad(3, 0), 24'd0);
    wr(ad(0, 1), 24'd2);
    wr(ad(0, 0), ctl(2, 1, 0, 0, 0, 0));
    wait_n(5);
    chk("R7 irq masked", irq[0], 0);
    rd(ad(0, 0), v); chk("R7 pending bit8", (v >> 8) & 1, 1);
    wr(ad(0, 0), ctl(2, 0, 0, 1, 0, 0));
    chk("R7 irq after enable", irq[0], 1);
    wr(ad(0, 0), ctl(2, 0, 0, 1, 0, 1));
    chk("R7 irq after clear", irq[0], 0);

    // R8 pulse width
    for (int t = 0; t < 3; t++) begin
      int w;
      w = (t == 0) ? 5 : (t == 1) ? 13 : int'($urandom_range(40, 1));
      wr(ad(1, 0), ctl(3, 1, 0, 0, 0, 1));
      pin_in[1] = 1'b1; wait_n(w); pin_in[1] = 1'b0; wait_n(4);
      rd(ad(1, 3), v); chk("R8 pulse width capture", v, w);
      rd(ad(1, 0), v); chk("R8 pending on capture", (v >> 8) & 1, 1);
    end

    // R9 period
    for (int t = 0; t < 2; t++) begin
      int pp;
      pp = (t == 0) ? 6 : int'($urandom_range(30, 4));
      wr(ad(0, 0), ctl(4, 1, 0, 0, 0, 1));
      for (int k = 0; k < 3; k++) begin
        pin_in[0] = 1'b1; wait_n(2); pin_in[0] = 1'b0; wait_n(pp - 2);
      end
      rd(ad(0, 3), v); chk("R9 period capture", v, pp);
    end

    // R10 toggle
    wr(ad(0, 1), 24'd3);
    wr(ad(0, 0), ctl(5, 1, 0, 0, 0, 1));
    chk("R3 toggle oe", pin_oe[0], 1);
    wait_n(3); chk("R10 toggle n=3", pin_out[0], 0);
    wait_n(1); chk("R10 toggle n=4", pin_out[0], 1);
    wait_n(4); chk("R10 toggle n=8", pin_out[0], 0);

    // R11 PWM
    wr(ad(1, 1), 24'd9);
    wr(ad(1, 2), 24'd3);
    wr(ad(1, 0), ctl(7, 1, 0, 0, 0, 1));
    for (int n = 1; n <= 20; n++) begin
      wait_n(1);
      chk("R11 pwm level", pin_out[1], ((n % 10) < 3) ? 1 : 0);
    end
    wr(ad(1, 2), 24'd0);
    wr(ad(1, 0), ctl(7, 1, 0, 0, 0, 1));
    for (int n = 1; n <= 12; n++) begin
      wait_n(1);
      chk("R11 pwm compare zero low", pin_out[1], 0);
    end

    // R12 watchdog
    wr(ad(2, 1), 24'd5);
    wr(ad(2, 0), ctl(6, 1, 0, 0, 0, 1));
    wait_n(4);
    wr(ad(2, 0), ctl(6, 1, 0, 0, 0, 1));
    wait_n(4);
    chk("R12 no expiry after restart", wd_rst_req, 0);
    wait_n(1);
    chk("R12 no expiry at n=5", wd_rst_req, 0);
    wait_n(1);
    chk("R12 expiry at n=6", wd_rst_req, 1);
    chk("R12 pin high on expiry", pin_out[2], 1);
    wait_n(3);
    rd(ad(2, 4), v); chk("R12 count held zero", v, 0);
    chk("R12 request held", wd_rst_req, 1);
    wr(ad(2, 0), ctl(6, 0, 0, 0, 0, 1));
    chk("R12 request cleared by write", wd_rst_req, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule